// File: doc/BRIEF.md
# Paged Receive Ring Pointer Manager

This block keeps the write pointer for a circular receive buffer held in a 16-bit local memory space. The memory is divided into 256-byte pages, and the ring is described by three page numbers: a first page, an end page that is one past the last page of the ring, and a boundary page that marks where unread data still sits. The block also keeps a packet-start page. It hands out the byte address for every received byte, moves to the next page when a page fills, and wraps from the end page back to the first page.

When a page fills and the page it would move to equals the boundary page, the block raises a sticky abort and stops issuing writes. When a packet finishes cleanly, the packet-start page moves past the pages that packet used, ready for the next packet. When a packet ends badly, or ends after an abort, the pointer returns to the packet-start page and the packet's space is reused. Any register write clears the abort.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the first page is RST_FIRST (default 0x40), the end page RST_END (0x60), the boundary RST_BND (0x40), the packet-start page equals the first page, dma_addr is {first page, 0x00}, and busy, abort and wr_en are 0.
- R2: A register write with cfg_sel=0 loads the first page and also sets the packet-start page to the same value; when idle, dma_addr becomes {new page, 0x00} on the next cycle. cfg_sel=1 loads the end page and cfg_sel=2 the boundary page.
- R3: pkt_start while idle sets busy and sets dma_addr to {packet-start page, 0x00} on the next cycle.
- R4: While busy and not aborted, byte_stb raises wr_en in the same cycle, with dma_addr[15:8] the page and dma_addr[7:0] the offset of that byte; a byte at an offset below 0xFF moves the offset up by one on the next cycle.
- R5: A byte at offset 0xFF moves dma_addr to offset 0x00 of the following page, where the following page is page+1, or the first page when page+1 equals the end page.
- R6: If that following page equals the boundary page, abort rises on the next cycle, dma_addr keeps its value and wr_en stays 0 for later bytes.
- R7: abort stays set until a register write (any cfg_sel), which clears it on the next cycle.
- R8: pkt_end_ok while busy and not aborted clears busy and sets the packet-start page to the page after the last page holding a byte of the packet (unchanged for an empty packet), following the same wrap rule as R5.
- R9: pkt_end_bad while busy, or pkt_end_ok while busy and aborted, clears busy, returns dma_addr to {packet-start page, 0x00} and leaves the packet-start page unchanged.
- R10: While idle, byte_stb and packet-end strobes are ignored: wr_en stays 0 and dma_addr and cur_page keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 first page, 1 end page, 2 boundary page |
| cfg_wdata | input | 8 | Page value to write |
| pkt_start | input | 1 | Packet begins |
| byte_stb | input | 1 | One received byte to place |
| pkt_end_ok | input | 1 | Packet ended without error |
| pkt_end_bad | input | 1 | Packet ended with error |
| wr_en | output | 1 | Write the current byte at dma_addr |
| dma_addr | output | 16 | Live local write address, page in bits 15:8, offset in 7:0 |
| abort | output | 1 | Sticky ring-full flag |
| busy | output | 1 | A packet is in progress |
| cur_page | output | 8 | Packet-start page |

## Verification
A wrong page link shows on dma_addr in the cycle after the byte at offset 0xFF, and a missed boundary compare shows as wr_en staying high on the very next byte. A wrong packet-start page is not visible during the packet but appears on cur_page one cycle after the packet ends and on dma_addr one cycle after the next pkt_start or after a bad end. The bench sweeps packet lengths around page multiples over a four-page ring, so every link, wrap and boundary case occurs at each ring position.

// File: rtl/rrm_pkg.sv
package rrm_pkg;
  typedef enum logic [1:0] {
    SEL_FIRST = 2'd0,
    SEL_END   = 2'd1,
    SEL_BND   = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;
endpackage

// File: rtl/rrm_regs.sv
module rrm_regs
  import rrm_pkg::*;
#(
  parameter int unsigned PAGE_W = 8,
  parameter logic [PAGE_W-1:0] RST_FIRST = 8'h40,
  parameter logic [PAGE_W-1:0] RST_END   = 8'h60,
  parameter logic [PAGE_W-1:0] RST_BND   = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [PAGE_W-1:0] cfg_wdata,
  output logic [PAGE_W-1:0] first_pg,
  output logic [PAGE_W-1:0] end_pg,
  output logic [PAGE_W-1:0] bnd_pg,
  output logic              first_ld
);
  logic first_en, end_en, bnd_en;

  always_comb begin
    first_en = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_FIRST);
    end_en   = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_END);
    bnd_en   = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_BND);
    first_ld = first_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_pg <= RST_FIRST;
      end_pg   <= RST_END;
      bnd_pg   <= RST_BND;
    end else begin
      if (first_en) first_pg <= cfg_wdata;
      if (end_en)   end_pg   <= cfg_wdata;
      if (bnd_en)   bnd_pg   <= cfg_wdata;
    end
  end
endmodule

// File: rtl/rrm_link.sv
module rrm_link #(
  parameter int unsigned PAGE_W = 8
) (
  input  logic [PAGE_W-1:0] page,
  input  logic [PAGE_W-1:0] first_pg,
  input  logic [PAGE_W-1:0] end_pg,
  input  logic [PAGE_W-1:0] bnd_pg,
  output logic [PAGE_W-1:0] nxt_pg,
  output logic              bnd_hit
);
  localparam logic [PAGE_W-1:0] PG_ONE = PAGE_W'(1);
  logic [PAGE_W-1:0] inc_pg;

  always_comb begin
    inc_pg  = page + PG_ONE;
    nxt_pg  = (inc_pg == end_pg) ? first_pg : inc_pg;
    bnd_hit = (nxt_pg == bnd_pg);
  end
endmodule

// File: rtl/rrm_dma_ptr.sv
module rrm_dma_ptr #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFF_W  = 8,
  parameter logic [PAGE_W-1:0] RST_FIRST = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              byte_stb,
  input  logic              pkt_end_ok,
  input  logic              pkt_end_bad,
  input  logic              cfg_we,
  input  logic              first_ld,
  input  logic [PAGE_W-1:0] first_val,
  input  logic [PAGE_W-1:0] nxt_pg,
  input  logic              bnd_hit,
  output logic [PAGE_W-1:0] page,
  output logic [OFF_W-1:0]  off,
  output logic              active,
  output logic              abort,
  output logic [PAGE_W-1:0] cur,
  output logic              wr_en
);
  localparam logic [OFF_W-1:0] OFF_ONE = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_MAX = {OFF_W{1'b1}};

  logic [PAGE_W-1:0] page_n, cur_n;
  logic [OFF_W-1:0]  off_n;
  logic              active_n, abort_n, end_any;

  always_comb begin
    end_any  = active && (pkt_end_ok || pkt_end_bad);
    wr_en    = active && byte_stb && !abort && !(pkt_end_ok || pkt_end_bad);
    page_n   = page;
    off_n    = off;
    active_n = active;
    abort_n  = abort;
    cur_n    = cur;
    if (cfg_we) abort_n = 1'b0;
    if (end_any) begin
      active_n = 1'b0;
      if (pkt_end_ok && !abort) begin
        cur_n = (off == '0) ? page : nxt_pg;
      end else begin
        page_n = cur;
        off_n  = '0;
      end
    end else if (pkt_start && !active) begin
      page_n   = cur;
      off_n    = '0;
      active_n = 1'b1;
    end else if (wr_en) begin
      if (off == OFF_MAX) begin
        if (bnd_hit) begin
          abort_n = 1'b1;
        end else begin
          page_n = nxt_pg;
          off_n  = '0;
        end
      end else begin
        off_n = off + OFF_ONE;
      end
    end
    if (first_ld) begin
      cur_n = first_val;
      if (!active_n) begin
        page_n = first_val;
        off_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page   <= RST_FIRST;
      off    <= '0;
      active <= 1'b0;
      abort  <= 1'b0;
      cur    <= RST_FIRST;
    end else begin
      page   <= page_n;
      off    <= off_n;
      active <= active_n;
      abort  <= abort_n;
      cur    <= cur_n;
    end
  end

  // R4: offset steps by one within a page
  a_r4_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off != OFF_MAX && !first_ld) |=> (off == $past(off) + OFF_ONE) && (page == $past(page)));

  // R6: filling a page whose successor is the boundary raises abort and freezes the pointer
  a_r6_bnd_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_MAX && bnd_hit && !first_ld) |=> abort && $stable(page) && $stable(off));

  // R7: abort holds until a register write
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !cfg_we) |=> abort);

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !(wr_en && off == OFF_MAX && bnd_hit)) |=> !abort);

  // R9: bad end restores the packet-start page
  a_r9_rollback: assert property (@(posedge clk) disable iff (!rst_n)
    (active && pkt_end_bad && !first_ld) |=> (page == $past(cur)) && (off == '0) && !active);

  // R10: nothing written while idle
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !wr_en);
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr #(
  parameter int unsigned PAGE_W = 8,
  parameter int unsigned OFF_W  = 8,
  parameter logic [PAGE_W-1:0] RST_FIRST = 8'h40,
  parameter logic [PAGE_W-1:0] RST_END   = 8'h60,
  parameter logic [PAGE_W-1:0] RST_BND   = 8'h40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [PAGE_W-1:0]        cfg_wdata,
  input  logic                     pkt_start,
  input  logic                     byte_stb,
  input  logic                     pkt_end_ok,
  input  logic                     pkt_end_bad,
  output logic                     wr_en,
  output logic [PAGE_W+OFF_W-1:0]  dma_addr,
  output logic                     abort,
  output logic                     busy,
  output logic [PAGE_W-1:0]        cur_page
);
  localparam logic [PAGE_W-1:0] PG_ONE  = PAGE_W'(1);
  localparam logic [OFF_W-1:0]  OFF_MAX = {OFF_W{1'b1}};

  logic [PAGE_W-1:0] first_pg, end_pg, bnd_pg, nxt_pg, page;
  logic [OFF_W-1:0]  off;
  logic              first_ld, bnd_hit;

  rrm_regs #(
    .PAGE_W(PAGE_W), .RST_FIRST(RST_FIRST), .RST_END(RST_END), .RST_BND(RST_BND)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .first_pg(first_pg), .end_pg(end_pg),
    .bnd_pg(bnd_pg), .first_ld(first_ld)
  );

  rrm_link #(.PAGE_W(PAGE_W)) u_link (
    .page(page), .first_pg(first_pg), .end_pg(end_pg), .bnd_pg(bnd_pg),
    .nxt_pg(nxt_pg), .bnd_hit(bnd_hit)
  );

  rrm_dma_ptr #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .RST_FIRST(RST_FIRST)) u_ptr (
    .clk(clk), .rst_n(rst_n), .pkt_start(pkt_start), .byte_stb(byte_stb),
    .pkt_end_ok(pkt_end_ok), .pkt_end_bad(pkt_end_bad), .cfg_we(cfg_we),
    .first_ld(first_ld), .first_val(cfg_wdata), .nxt_pg(nxt_pg),
    .bnd_hit(bnd_hit), .page(page), .off(off), .active(busy),
    .abort(abort), .cur(cur_page), .wr_en(wr_en)
  );

  assign dma_addr = {page, off};

  // R5: page link with wrap from the end page to the first page
  a_r5_link_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_MAX && nxt_pg != bnd_pg && !cfg_we) |=>
      (page == (($past(page) + PG_ONE == $past(end_pg)) ? $past(first_pg) : $past(page) + PG_ONE))
      && (off == '0));

  // R3: a packet starts at the packet-start page
  a_r3_start_page: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_start && !busy && !cfg_we) |=> busy && (page == $past(cur_page)) && (off == '0));
endmodule

// File: tb/tb_rx_ring_mgr.sv
`timescale 1ns/1ps
module tb_rx_ring_mgr;
  logic        clk, rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_wdata;
  logic        pkt_start, byte_stb, pkt_end_ok, pkt_end_bad;
  logic        wr_en, abort, busy;
  logic [15:0] dma_addr;
  logic [7:0]  cur_page;

  int n_chk, n_fail;
  int rs, re, bnd, cur;

  rx_ring_mgr dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .pkt_start(pkt_start), .byte_stb(byte_stb),
    .pkt_end_ok(pkt_end_ok), .pkt_end_bad(pkt_end_bad), .wr_en(wr_en),
    .dma_addr(dma_addr), .abort(abort), .busy(busy), .cur_page(cur_page)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int pg(int k);
    return rs + ((cur - rs + k) % (re - rs));
  endfunction

  function automatic int prev_pg(int p);
    return (p == rs) ? re - 1 : p - 1;
  endfunction

  task automatic wr_reg(input int sel, input int val);
    cfg_we = 1'b1; cfg_sel = sel[1:0]; cfg_wdata = val[7:0];
    tick();
    cfg_we = 1'b0;
    if (sel == 0) begin rs = val; cur = val; end
    else if (sel == 1) re = val;
    else if (sel == 2) bnd = val;
    #1;
    chk(abort == 1'b0, "R7 clear on write", abort, 0);
  endtask

  task automatic send_pkt(input int len, input bit good);
    bit ab;
    int last;
    ab = 0;
    pkt_start = 1'b1;
    tick();
    pkt_start = 1'b0;
    #1;
    chk(busy == 1'b1, "R3 busy", busy, 1);
    chk(dma_addr == 16'(cur * 256), "R3 start addr", dma_addr, cur * 256);
    last = cur * 256;
    for (int i = 0; i < len; i++) begin
      byte_stb = 1'b1;
      #1;
      if (!ab) begin
        last = pg(i / 256) * 256 + (i % 256);
        chk(wr_en == 1'b1, "R4 wr_en", wr_en, 1);
        if (i % 256 == 0 && i > 0)
          chk(dma_addr == 16'(last), "R5 page link", dma_addr, last);
        else
          chk(dma_addr == 16'(last), "R4 byte addr", dma_addr, last);
      end else begin
        chk(wr_en == 1'b0, "R6 no write after abort", wr_en, 0);
        chk(dma_addr == 16'(last), "R6 addr held", dma_addr, last);
      end
      tick();
      if (!ab && ((i + 1) % 256 == 0) && pg((i + 1) / 256) == bnd) ab = 1;
      chk(abort == ab, "R6 abort flag", abort, ab);
    end
    byte_stb = 1'b0;
    if (good) pkt_end_ok = 1'b1; else pkt_end_bad = 1'b1;
    tick();
    pkt_end_ok = 1'b0; pkt_end_bad = 1'b0;
    #1;
    chk(busy == 1'b0, "R8 busy cleared", busy, 0);
    chk(abort == ab, "R7 abort kept after end", abort, ab);
    if (good && !ab) begin
      cur = pg((len + 255) / 256);
      chk(cur_page == 8'(cur), "R8 next start page", cur_page, cur);
    end else begin
      chk(cur_page == 8'(cur), "R9 start page kept", cur_page, cur);
      chk(dma_addr == 16'(cur * 256), "R9 rollback addr", dma_addr, cur * 256);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lens[14] = '{0, 1, 2, 255, 256, 257, 511, 512, 513, 700, 767, 768, 769, 1000};
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0; cfg_wdata = 8'h00;
    pkt_start = 1'b0; byte_stb = 1'b0; pkt_end_ok = 1'b0; pkt_end_bad = 1'b0;
    rs = 'h40; re = 'h60; bnd = 'h40; cur = 'h40;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk(dma_addr == 16'h4000, "R1 reset addr", dma_addr, 'h4000);
    chk(cur_page == 8'h40, "R1 reset start page", cur_page, 'h40);
    chk(busy == 1'b0 && abort == 1'b0 && wr_en == 1'b0, "R1 reset flags",
        {busy, abort, wr_en}, 0);

    // R10: strobes while idle
    byte_stb = 1'b1; pkt_end_ok = 1'b1; pkt_end_bad = 1'b1;
    #1;
    chk(wr_en == 1'b0, "R10 idle no write", wr_en, 0);
    tick();
    byte_stb = 1'b0; pkt_end_ok = 1'b0; pkt_end_bad = 1'b0;
    #1;
    chk(dma_addr == 16'h4000, "R10 idle addr kept", dma_addr, 'h4000);
    chk(cur_page == 8'h40, "R10 idle start page kept", cur_page, 'h40);

    // R2: first-page write reloads the packet-start page
    wr_reg(0, 'h41);
    chk(cur_page == 8'h41, "R2 start page load", cur_page, 'h41);
    chk(dma_addr == 16'h4100, "R2 idle addr load", dma_addr, 'h4100);
    wr_reg(0, 'h40);
    wr_reg(1, 'h44);

    // sweep lengths around page multiples, ring of four pages
    for (int r = 0; r < 2; r++) begin
      for (int j = 0; j < 14; j++) begin
        wr_reg(2, prev_pg(cur));
        send_pkt(lens[j], ((j + r) % 3) != 2);
      end
    end

    // R7: abort persists while idle
    wr_reg(2, pg(1));
    send_pkt(400, 1'b1);
    repeat (3) tick();
    chk(abort == 1'b1, "R7 abort sticky idle", abort, 1);
    wr_reg(2, prev_pg(cur));
    chk(abort == 1'b0, "R7 abort cleared", abort, 0);

    // R2: moved ring start, two-page ring
    wr_reg(0, 'h42);
    chk(cur_page == 8'h42, "R2 start page load 2", cur_page, 'h42);
    send_pkt(600, 1'b1);
    wr_reg(2, 'h41);
    send_pkt(300, 1'b1);
    send_pkt(513, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule